// File: doc/BRIEF.md
# Gated Parallel Port Section

This block is one 8-bit bidirectional parallel port of a peripheral controller. It holds the direction and output-data settings, watches input lines with per-bit "ones catchers" that remember a low-to-high transition, keeps an interrupt pending (IP) and an interrupt under service (IUS) flag, raises a transfer request when a strobed input byte is waiting, and runs an interlocked input handshake with a peer.

A port enable bit puts the section into an initialization mode while it is 0. In that mode every line is left undriven, the catchers are cleared, no request is raised and IP cannot be set, but IP and IUS keep their values. Software can still read and write every register, so the direction and first output byte can be loaded before the drivers turn on. A second enable bit, shared with another section of the chip, keeps the handshake engine idle and deaf to its strobe until it is set. Configuration can therefore happen in any order, as long as a section is fully set up before its enable is raised.

Top module: `pio_section`

## Requirements
- R1: After reset all registers read 0, no line is driven (pad_oe = 0), and hs_ack, req_out and int_req are 0.
- R2: While the port enable (CTRL at address 0, bit 0) is 0, pad_oe is 0 from the next clock edge on.
- R3: When the port enable is set, pad_oe still reads 0 right after the write edge and equals DIR (address 1, 1 = drive) one edge later; pad_out then carries the last byte written to OUT (address 2), even if it was written while disabled.
- R4: While the port enable is 0 the catchers (CATCH, address 4) read 0 and an input rising edge leaves them at 0.
- R5: While enabled, a rising edge on a bit with DIR = 0 sets that CATCH bit, a bit with DIR = 1 never catches; a set bit holds until a CATCH write with 0 in that position, a 1 in the write leaves it.
- R6: A catcher capture or a handshake capture sets IP (INTST at address 5, bit 0) only while enabled; while disabled IP and IUS (bit 1) keep their values unless INTST is written.
- R7: int_req is 1 exactly when IP is 1, the interrupt enable (CTRL bit 2) is 1 and IUS is 0.
- R8: req_out is never 1 while the port enable is 0; it is 1 when the port and request enable (CTRL bit 3) are set and a captured byte is waiting.
- R9: While the handshake enable (CTRL bit 1) is 0, hs_ack is 0 from the next edge and a strobe leaves the capture register (CAP, address 6) unchanged.
- R10: With both enables set and the engine armed, a rising hs_strobe latches pad_in into CAP, sets IP and the waiting flag, and raises hs_ack until hs_strobe falls.
- R11: DIR, OUT, CTRL and INTST can be written and read back while the port is disabled.
- R12: A read of CAP (bus_rd at address 6) clears the waiting flag, so req_out drops after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only on CAP) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Line input values |
| pad_out | output | 8 | Line output values |
| pad_oe | output | 8 | Per-line driver enable, 0 = high impedance |
| hs_strobe | input | 1 | Handshake strobe from the peer |
| hs_ack | output | 1 | Handshake acknowledge to the peer |
| req_out | output | 1 | Transfer request, captured byte waiting |
| int_req | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a change of enable while something is in flight: the handshake engine sitting in its acknowledge state when the handshake enable is withdrawn, or a captured byte waiting when the port enable drops and returns. The stimulus holds the strobe high to park the engine in acknowledge, then rewrites the control register and checks the acknowledge and request outputs edge by edge. The enable-to-driver delay is probed by sampling pad_oe both right after the enabling write and one edge later, with the output byte loaded while disabled.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_DIR   = 1;
  localparam int ADDR_OUT   = 2;
  localparam int ADDR_PIN   = 3;
  localparam int ADDR_CATCH = 4;
  localparam int ADDR_INTST = 5;
  localparam int ADDR_CAP   = 6;

  localparam int CTRL_W      = 4;
  localparam int CB_PORT_EN  = 0;
  localparam int CB_HS_EN    = 1;
  localparam int CB_INT_EN   = 2;
  localparam int CB_REQ_EN   = 3;

  localparam int IB_IP  = 0;
  localparam int IB_IUS = 1;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_ARMED = 2'd1,
    HS_ACK   = 2'd2
  } hs_state_t;

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pio_catchers.sv
module pio_catchers #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [DW-1:0] drive_mask,
  input  logic [DW-1:0] pin,
  input  logic          clr_wr,
  input  logic [DW-1:0] clr_data,
  output logic [DW-1:0] catch_q,
  output logic          any_set
);

  logic [DW-1:0] pin_q;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] catch_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else begin
      pin_q <= pin;
    end
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    always_comb begin
      set_vec[b] = arm && !drive_mask[b] && pin[b] && !pin_q[b];
      if (!arm) begin
        catch_d[b] = 1'b0;
      end else if (set_vec[b]) begin
        catch_d[b] = 1'b1;
      end else if (clr_wr && !clr_data[b]) begin
        catch_d[b] = 1'b0;
      end else begin
        catch_d[b] = catch_q[b];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        catch_q[b] <= 1'b0;
      end else begin
        catch_q[b] <= catch_d[b];
      end
    end
  end

  assign any_set = |set_vec;

endmodule

// File: rtl/pio_handshake.sv
module pio_handshake
  import pio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic strobe,
  output logic ack,
  output logic cap_pulse
);

  hs_state_t state_q;
  hs_state_t state_d;
  logic      stb_q;
  logic      stb_rise;

  assign stb_rise = strobe && !stb_q;

  always_comb begin
    state_d   = state_q;
    cap_pulse = 1'b0;
    if (!run) begin
      state_d = HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE:  state_d = HS_ARMED;
        HS_ARMED: begin
          if (stb_rise) begin
            state_d   = HS_ACK;
            cap_pulse = 1'b1;
          end
        end
        HS_ACK: begin
          if (!strobe) begin
            state_d = HS_ARMED;
          end
        end
        default: state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= strobe;
    end
  end

  assign ack = (state_q == HS_ACK);

endmodule

// File: rtl/pio_section.sv
module pio_section
  import pio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe,
  input  logic          hs_strobe,
  output logic          hs_ack,
  output logic          req_out,
  output logic          int_req
);

  logic srst_n;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     dir_q, dir_d;
  logic [DW-1:0]     out_q, out_d;
  logic [DW-1:0]     oe_q, oe_d;
  logic [DW-1:0]     cap_q, cap_d;
  logic              cap_full_q, cap_full_d;
  logic              ip_q, ip_d;
  logic              ius_q, ius_d;

  logic wr_ctrl, wr_dir, wr_out, wr_catch, wr_intst, rd_cap;
  logic port_en, hs_en, int_en, req_en;
  logic [DW-1:0] catch_q;
  logic catch_evt;
  logic cap_pulse;

  pio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign wr_ctrl  = bus_wr && (bus_addr == AW'(ADDR_CTRL));
  assign wr_dir   = bus_wr && (bus_addr == AW'(ADDR_DIR));
  assign wr_out   = bus_wr && (bus_addr == AW'(ADDR_OUT));
  assign wr_catch = bus_wr && (bus_addr == AW'(ADDR_CATCH));
  assign wr_intst = bus_wr && (bus_addr == AW'(ADDR_INTST));
  assign rd_cap   = bus_rd && (bus_addr == AW'(ADDR_CAP));

  assign port_en = ctrl_q[CB_PORT_EN];
  assign hs_en   = ctrl_q[CB_HS_EN];
  assign int_en  = ctrl_q[CB_INT_EN];
  assign req_en  = ctrl_q[CB_REQ_EN];

  pio_catchers #(.DW(DW)) u_catch (
    .clk        (clk),
    .rst_n      (srst_n),
    .arm        (port_en),
    .drive_mask (dir_q),
    .pin        (pad_in),
    .clr_wr     (wr_catch),
    .clr_data   (bus_wdata),
    .catch_q    (catch_q),
    .any_set    (catch_evt)
  );

  pio_handshake u_hs (
    .clk       (clk),
    .rst_n     (srst_n),
    .run       (port_en && hs_en),
    .strobe    (hs_strobe),
    .ack       (hs_ack),
    .cap_pulse (cap_pulse)
  );

  // next-state logic
  always_comb begin
    ctrl_d     = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    dir_d      = wr_dir  ? bus_wdata : dir_q;
    out_d      = wr_out  ? bus_wdata : out_q;
    oe_d       = port_en ? dir_q : '0;

    cap_d      = cap_q;
    cap_full_d = cap_full_q;
    if (cap_pulse) begin
      cap_d      = pad_in;
      cap_full_d = 1'b1;
    end else if (rd_cap) begin
      cap_full_d = 1'b0;
    end

    ip_d  = ip_q;
    ius_d = ius_q;
    if (wr_intst) begin
      ip_d  = bus_wdata[IB_IP];
      ius_d = bus_wdata[IB_IUS];
    end else if (port_en && (catch_evt || cap_pulse)) begin
      ip_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q     <= '0;
      dir_q      <= '0;
      out_q      <= '0;
      oe_q       <= '0;
      cap_q      <= '0;
      cap_full_q <= 1'b0;
      ip_q       <= 1'b0;
      ius_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      dir_q      <= dir_d;
      out_q      <= out_d;
      oe_q       <= oe_d;
      cap_q      <= cap_d;
      cap_full_q <= cap_full_d;
      ip_q       <= ip_d;
      ius_q      <= ius_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      AW'(ADDR_CTRL):  bus_rdata = DW'(ctrl_q);
      AW'(ADDR_DIR):   bus_rdata = dir_q;
      AW'(ADDR_OUT):   bus_rdata = out_q;
      AW'(ADDR_PIN):   bus_rdata = pad_in;
      AW'(ADDR_CATCH): bus_rdata = catch_q;
      AW'(ADDR_INTST): bus_rdata = DW'({ius_q, ip_q});
      AW'(ADDR_CAP):   bus_rdata = cap_q;
      default:         bus_rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q;
  assign req_out = port_en && req_en && cap_full_q;
  assign int_req = ip_q && int_en && !ius_q;

endmodule

// File: rtl/pio_section_chk.sv
module pio_section_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          hs_en,
  input logic [DW-1:0] dir,
  input logic [DW-1:0] pad_oe,
  input logic [DW-1:0] catch_q,
  input logic          ip,
  input logic          ius,
  input logic          intst_wr,
  input logic          hs_ack,
  input logic          req_out,
  input logic          int_req
);

  AST_OE_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (pad_oe == '0)); // R2

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> (pad_oe == $past(dir))); // R3

  AST_CATCH_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (catch_q == '0)); // R4

  AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !intst_wr) |=> (ip == $past(ip) && ius == $past(ius))); // R6

  AST_NO_INT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ius |-> !int_req); // R7

  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !req_out); // R8

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |=> !hs_ack); // R9

endmodule

bind pio_section pio_section_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .port_en  (port_en),
  .hs_en    (hs_en),
  .dir      (dir_q),
  .pad_oe   (pad_oe),
  .catch_q  (catch_q),
  .ip       (ip_q),
  .ius      (ius_q),
  .intst_wr (wr_intst),
  .hs_ack   (hs_ack),
  .req_out  (req_out),
  .int_req  (int_req)
);

// File: tb/test_pio_section.sv
module test_pio_section;

  localparam int DW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] pad_in = '0;
  logic [DW-1:0] pad_out;
  logic [DW-1:0] pad_oe;
  logic          hs_strobe = 1'b0;
  logic          hs_ack;
  logic          req_out;
  logic          int_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pio_section #(.DW(DW), .AW(AW)) i_pio_section (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .hs_strobe(hs_strobe), .hs_ack(hs_ack),
    .req_out(req_out), .int_req(int_req)
  );

  // addr[18:16], wdata[15:8], expected readback[7:0]; port disabled
  localparam logic [18:0] VEC [0:6] = '{
    {3'd1, 8'hA5, 8'hA5},
    {3'd2, 8'h3C, 8'h3C},
    {3'd5, 8'h02, 8'h02},
    {3'd5, 8'h03, 8'h03},
    {3'd5, 8'h00, 8'h00},
    {3'd0, 8'h0C, 8'h0C},
    {3'd4, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 ack/req/int", {5'b0, hs_ack, req_out, int_req}, 8'h00);
    rd(3'd0, v); chk("R1 CTRL", v, 8'h00);
    rd(3'd1, v); chk("R1 DIR", v, 8'h00);
    rd(3'd2, v); chk("R1 OUT", v, 8'h00);
    rd(3'd5, v); chk("R1 INTST", v, 8'h00);

    // R11 register access while disabled (table walk)
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk("R11 readback", v, VEC[i][7:0]);
    end
    chk("R2 oe while disabled", pad_oe, 8'h00);

    // R4 R6 disabled: no catch, no IP
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h0F);
    wr(3'd2, 8'h5A);
    step(); pad_in = 8'hF0;
    step(); step();
    rd(3'd4, v); chk("R4 catch disabled", v, 8'h00);
    rd(3'd5, v); chk("R6 IP not set disabled", v, 8'h00);
    chk("R2 oe disabled", pad_oe, 8'h00);

    // R3 enable timing
    wr(3'd0, 8'h01);
    chk("R3 oe one edge late", pad_oe, 8'h00);
    step();
    chk("R3 oe = DIR", pad_oe, 8'h0F);
    chk("R3 pad_out = early OUT", pad_out, 8'h5A);
    rd(3'd4, v); chk("R5 no spurious catch", v, 8'h00);

    // R5 R6 catching
    pad_in = 8'h00; step();
    pad_in = 8'h11; step();
    rd(3'd4, v); chk("R5 catch input bit only", v, 8'h10);
    rd(3'd5, v); chk("R6 IP set by catch", v, 8'h01);
    chk("R7 int_req off int_en=0", {7'b0, int_req}, 8'h00);
    wr(3'd0, 8'h05);
    chk("R7 int_req on", {7'b0, int_req}, 8'h01);
    wr(3'd5, 8'h03);
    chk("R7 int_req off IUS", {7'b0, int_req}, 8'h00);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R5 write 1 keeps", v, 8'h10);
    wr(3'd4, 8'hEF);
    rd(3'd4, v); chk("R5 write 0 clears", v, 8'h00);

    // R6 R2 R4 flags retained while disabled
    wr(3'd5, 8'h02);
    wr(3'd0, 8'h04);
    step();
    chk("R2 oe off after disable", pad_oe, 8'h00);
    pad_in = 8'h00; step();
    pad_in = 8'h10; step(); step();
    rd(3'd4, v); chk("R4 no catch disabled", v, 8'h00);
    rd(3'd5, v); chk("R6 IUS kept, IP not set", v, 8'h02);
    wr(3'd5, 8'h03);
    repeat (3) step();
    rd(3'd5, v); chk("R6 IP+IUS retained", v, 8'h03);
    wr(3'd5, 8'h00);

    // R9 handshake enable off
    wr(3'd0, 8'h09);
    step(); step();
    pad_in = 8'h17; hs_strobe = 1'b1; step();
    chk("R9 ack idle", {7'b0, hs_ack}, 8'h00);
    step(); hs_strobe = 1'b0; step();
    rd(3'd6, v); chk("R9 CAP unchanged", v, 8'h00);
    chk("R8 no req without capture", {7'b0, req_out}, 8'h00);

    // R10 R8 R12 handshake
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h0B);
    step(); step();
    pad_in = 8'h1C; hs_strobe = 1'b1; step();
    chk("R10 ack high", {7'b0, hs_ack}, 8'h01);
    chk("R8 req on", {7'b0, req_out}, 8'h01);
    rd(3'd5, v); chk("R10 IP set", v, 8'h01);
    hs_strobe = 1'b0; step();
    chk("R10 ack drops", {7'b0, hs_ack}, 8'h00);
    wr(3'd0, 8'h0A);
    chk("R8 req off disabled", {7'b0, req_out}, 8'h00);
    wr(3'd0, 8'h0B);
    chk("R8 req back", {7'b0, req_out}, 8'h01);
    rd(3'd6, v); chk("R10 CAP data", v, 8'h1C);
    chk("R12 req cleared by read", {7'b0, req_out}, 8'h00);

    // R9 enable withdrawn during acknowledge
    step(); step();
    hs_strobe = 1'b1; step();
    chk("R10 ack again", {7'b0, hs_ack}, 8'h01);
    wr(3'd0, 8'h09);
    step();
    chk("R9 ack forced idle", {7'b0, hs_ack}, 8'h00);
    hs_strobe = 1'b0; step();

    done = 1'b1;
    summary();
  end

endmodule